// File: doc/BRIEF.md
# Fall-Through Bubble FIFO

This block is a first-in first-out buffer of 64 words of 4 bits. It is built as a chain of storage cells with no read or write pointers. Each cell holds one word and a valid flag. A word written at the input end moves forward on its own, one cell per clock, into any empty cell ahead of it. Stored words therefore collect at the output end, and the empty cells drift back toward the input.

Each side has a level strobe and a ready flag, sampled on the single system clock. On the write side, `in_rdy` high means the first cell is free. A rising `shift_in` captures `din`, and the first cell then holds that word for as long as `shift_in` stays high. On the read side, `out_rdy` high means a word sits in the output stage. A rising `shift_out` takes that word: `out_rdy` drops, but `dout` keeps the word until the strobe is released. On release, the next word moves in.

Back-pressure works through the ready flags alone. A strobe edge that arrives while its ready flag is low is discarded. A strobe must be seen low for at least one clock before another transfer on that side can happen. An active-low reset empties the chain.

Top module: `bubble_fifo`

## Requirements
- R1: While `rst_n` is low, `in_rdy` is 1, `out_rdy` is 0 and `dout` is 0. A reset asserted during operation discards every stored word.
- R2: A rising edge of `shift_in` sampled while `in_rdy` is 1 stores `din`. `in_rdy` is 0 after that clock edge and stays 0 while `shift_in` remains high.
- R3: A rising edge of `shift_in` sampled while `in_rdy` is 0 stores nothing. Keeping `shift_in` high afterwards stores nothing either.
- R4: Take a word captured into an empty buffer, with `shift_in` low from the next clock edge onward. `out_rdy` becomes 1 at the 63rd rising clock edge after the capturing edge (DEPTH-1), and not earlier.
- R5: Words leave in the order they were written. The buffer holds exactly 64 words. Once 64 words are stored, `in_rdy` stays 0.
- R6: A rising edge of `shift_out` sampled while `out_rdy` is 1 makes `out_rdy` 0 after that edge. `dout` keeps the taken word unchanged while `shift_out` stays high.
- R7: Suppose a word waits directly behind the output stage. At the first clock edge that samples `shift_out` low after a take, that word enters the output stage, and `out_rdy` is 1 after that edge.
- R8: While `out_rdy` is 0, `dout` changes only at an edge that also raises `out_rdy`. After the last word is taken, `dout` keeps that word's value.
- R9: A `shift_out` edge that rises while `out_rdy` is 0 takes nothing. A word that arrives while that strobe is still held high stays available, with `out_rdy` at 1.
- R10: When the buffer is full, the release edge of a take moves every stored word forward at once, so `in_rdy` is 1 after that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, empties the buffer |
| shift_in | input | 1 | Write strobe; its rising edge captures `din` |
| din | input | 4 | Word to be written |
| in_rdy | output | 1 | First cell empty; a write strobe will be accepted |
| shift_out | input | 1 | Read strobe; its rising edge takes the output word, its release advances the next one |
| out_rdy | output | 1 | A word not yet taken is present on `dout` |
| dout | output | 4 | Word in the output stage |

## Verification
A lost or stuck valid flag in the chain shows up at the ports as a word that never arrives, a gap in the read order, or an extra word after draining. The bench counts every word it reads back. A cell that fails to advance shows up as a late rise of `out_rdy`; it is caught within the 63-cycle travel window, because the bench samples the exact arrival edge. A wrong handshake state shows up one edge after the strobe edge, as a ready flag that does not drop or `dout` changing under a held strobe. A full chain that does not shift as a whole shows up as `in_rdy` staying low one edge after a read from a full buffer.

// File: rtl/bfifo_pkg.sv
package bfifo_pkg;
  // handshake state of the output stage
  typedef enum logic {
    OS_IDLE  = 1'b0,
    OS_TAKEN = 1'b1
  } ostage_e;
endpackage

// File: rtl/bfifo_strobe.sv
// Samples a level strobe and flags its rising edge.
module bfifo_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/bfifo_cell.sv
// One storage cell of the fall-through chain.
module bfifo_cell #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             drain,
  input  logic [WIDTH-1:0] d_in,
  output logic             vld,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= 1'b0;
      q   <= '0;
    end else begin
      vld <= (vld & ~drain) | load;
      if (load) q <= d_in;
    end
  end

  // R5
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!vld || drain));
endmodule

// File: rtl/bfifo_out_ctl.sv
// Two-phase handshake of the output stage.
module bfifo_out_ctl
  import bfifo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic so_lvl,
  input  logic so_rise,
  input  logic stage_vld,
  output logic out_rdy,
  output logic leave
);
  ostage_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      OS_IDLE:  if (so_rise && stage_vld) state_d = OS_TAKEN;
      OS_TAKEN: if (!so_lvl)              state_d = OS_IDLE;
      default:                            state_d = OS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= OS_IDLE;
    else        state_q <= state_d;
  end

  assign out_rdy = stage_vld & (state_q == OS_IDLE);
  assign leave   = (state_q == OS_TAKEN) & ~so_lvl;

  // R6
  taken_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == OS_TAKEN && so_lvl) |=> !out_rdy);
endmodule

// File: rtl/bubble_fifo.sv
module bubble_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] din,
  output logic             in_rdy,
  input  logic             shift_out,
  output logic             out_rdy,
  output logic [WIDTH-1:0] dout
);
  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] vld;
  logic [DEPTH-1:0] load;
  logic [DEPTH-1:0] drain;
  logic [WIDTH-1:0] cdat [DEPTH];

  logic si_rise, so_rise, leave, capture, in_hold_q;

  bfifo_strobe u_si (.clk(clk), .rst_n(rst_n), .lvl(shift_in),  .rise(si_rise));
  bfifo_strobe u_so (.clk(clk), .rst_n(rst_n), .lvl(shift_out), .rise(so_rise));

  assign capture = si_rise & ~vld[0];
  assign in_rdy  = ~vld[0];

  // the first cell keeps a freshly captured word while its strobe is held
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        in_hold_q <= 1'b0;
    else if (capture)  in_hold_q <= 1'b1;
    else if (!shift_in) in_hold_q <= 1'b0;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic [WIDTH-1:0] src;
    if (i == 0) begin : g_head
      assign load[i] = capture;
      assign src     = din;
    end else begin : g_body
      assign load[i] = drain[i-1];
      assign src     = cdat[i-1];
    end

    if (i == LAST) begin : g_tail
      assign drain[i] = leave;
    end else if (i == 0) begin : g_first
      assign drain[i] = vld[i] & ~(in_hold_q & shift_in) & (~vld[i+1] | drain[i+1]);
    end else begin : g_mid
      assign drain[i] = vld[i] & (~vld[i+1] | drain[i+1]);
    end

    bfifo_cell #(.WIDTH(WIDTH)) u_cell (
      .clk(clk), .rst_n(rst_n), .load(load[i]), .drain(drain[i]),
      .d_in(src), .vld(vld[i]), .q(cdat[i])
    );
  end

  bfifo_out_ctl u_octl (
    .clk(clk), .rst_n(rst_n), .so_lvl(shift_out), .so_rise(so_rise),
    .stage_vld(vld[LAST]), .out_rdy(out_rdy), .leave(leave)
  );

  assign dout = cdat[LAST];

  // R2
  capture_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (si_rise && in_rdy) |=> !in_rdy);

  // R2
  in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold_q && shift_in) |=> !in_rdy);

  // R6
  take_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (so_rise && out_rdy) |=> (!out_rdy && $stable(dout)));

  // R8
  idle_dout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_rdy |=> (out_rdy || $stable(dout)));
endmodule

// File: tb/bubble_fifo_test.sv
module bubble_fifo_test;
  localparam int D = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       shift_in = 1'b0;
  logic       shift_out = 1'b0;
  logic [3:0] din = 4'h0;
  logic       in_rdy, out_rdy;
  logic [3:0] dout;
  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  bubble_fifo uut (
    .clk(clk), .rst_n(rst_n), .shift_in(shift_in), .din(din), .in_rdy(in_rdy),
    .shift_out(shift_out), .out_rdy(out_rdy), .dout(dout)
  );

  // bit 4: 1 = write, 0 = read; bits 3:0: data written or expected
  localparam logic [4:0] VEC [8] = '{
    5'h13, 5'h1A, 5'h03, 5'h15, 5'h0A, 5'h05, 5'h1C, 5'h0C
  };

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] d);
    din = d;
    shift_in = 1'b1;
    @(negedge clk);
    shift_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic pop(input logic [3:0] exp, input string req);
    int n = 0;
    while (!out_rdy && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(req, out_rdy, 1);
    shift_out = 1'b1;
    @(negedge clk);
    check(req, out_rdy, 0);
    check(req, dout, exp);
    @(negedge clk);
    check(req, dout, exp);
    shift_out = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (D + 6) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 in_rdy", in_rdy, 1);
    check("R1 out_rdy", out_rdy, 0);
    check("R1 dout", dout, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R4 watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    do_reset();

    // vector table: interleaved writes and reads, order kept (R5)
    for (int k = 0; k < 8; k++) begin
      if (VEC[k][4]) push(VEC[k][3:0]);
      else           pop(VEC[k][3:0], "R5 order");
    end

    // R2: ready drops on capture and stays low while strobe held
    settle();
    din = 4'h9;
    shift_in = 1'b1;
    @(negedge clk);
    check("R2 in_rdy after capture", in_rdy, 0);
    repeat (3) @(negedge clk);
    check("R2 in_rdy while held", in_rdy, 0);
    check("R2 word held in first cell", out_rdy, 0);
    shift_in = 1'b0;
    @(negedge clk);
    check("R2 in_rdy after release", in_rdy, 1);
    pop(4'h9, "R2 held word");

    // R4: travel time through an empty chain
    settle();
    push(4'h6);
    repeat (D - 3) @(negedge clk);
    check("R4 not yet arrived", out_rdy, 0);
    @(negedge clk);
    check("R4 arrival edge", out_rdy, 1);
    check("R4 arrival data", dout, 6);
    pop(4'h6, "R4");

    // R7: back-to-back reads
    push(4'h1);
    push(4'h2);
    push(4'h3);
    settle();
    pop(4'h1, "R7");
    check("R7 next word ready at release", out_rdy, 1);
    check("R7 next word data", dout, 2);
    pop(4'h2, "R7");
    pop(4'h3, "R7");

    // R9: strobe held from before arrival takes nothing
    settle();
    shift_out = 1'b1;
    @(negedge clk);
    push(4'hE);
    settle();
    check("R9 word stays available", out_rdy, 1);
    check("R9 data", dout, 14);
    shift_out = 1'b0;
    @(negedge clk);
    check("R9 still available after release", out_rdy, 1);
    pop(4'hE, "R9");

    // R5 / R3 / R10: fill completely, reject extra, drain in order
    for (int k = 0; k < D; k++) push(4'(k));
    settle();
    check("R5 full in_rdy", in_rdy, 0);
    push(4'hB);
    settle();
    check("R3 still full", in_rdy, 0);
    pop(4'h0, "R5 first of full");
    check("R10 in_rdy after read from full", in_rdy, 1);
    for (int k = 1; k < D; k++) pop(4'(k), "R5 drain order");
    settle();
    check("R3 extra word not stored", out_rdy, 0);
    check("R8 dout keeps last word", dout, 15);
    check("R8 in_rdy when empty", in_rdy, 1);

    // R1: reset during operation discards words
    push(4'h7);
    push(4'h8);
    settle();
    do_reset();
    settle();
    check("R1 nothing after reset", out_rdy, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule